// File: doc/BRIEF.md
# Host Command and Status Port with Register Windows

This block is the device-side half of a network controller's host register interface. The host uses one 16-bit port for two jobs. A write carries a command: a 5-bit opcode in bits 15:11 and an 11-bit argument in bits 10:0. A read returns the live status word. That word holds the latched event flags, a busy flag for the command in flight, and the number of the register bank that is currently selected.

The block keeps a bank selector. It picks which of up to eight register banks the rest of the chip decodes at the shared windowed offsets. It also keeps two event masks. The indication mask decides which events may latch. The interrupt mask decides which latched events raise the interrupt latch. Receive and transmit enables and the three reset actions leave the block as level outputs. The controller's datapath reports its events back through a pulse input, one bit per status flag.

Reset commands keep the port busy for a set number of cycles. Any command written during that time is dropped and recorded as a protocol error.

Top module: `hcp_top`

## Requirements
- R1: While rst_n is low and after its release, stat_rd, win_sel and every level output read 0.
- R2: Opcode 0x01 loads the bank selector from argument bits 2:0. Upper argument bits are ignored. The selector appears on win_sel and in stat_rd bits 15:13.
- R3: stat_rd bit 12 is the busy flag and bits 11 and 3 always read 0. Bits 10:0 hold the latched flags: 0 interrupt latch, 1 host error, 2 transmit done, 4 receive done, 5 receive early, 6 interrupt requested, 7 statistics update, 8 link change, 9 download done, 10 upload done.
- R4: A high on ev_in[i], for i in 1, 2 and 4..10, sets flag i at the next clock edge only when indication-mask bit i is set. Opcode 0x0F loads the indication mask from the argument. ev_in[0] and ev_in[3] never latch anything.
- R5: Opcode 0x0D clears every latched flag whose argument bit is 1; an argument of 0x661 clears flags 0, 5, 6, 9 and 10. If an event arrives in the same cycle as the clear, the event wins.
- R6: Opcode 0x0E loads the interrupt mask. When an event latches and its interrupt-mask bit is set, flag 0 is set as well. The irq output equals flag 0.
- R7: Opcodes 0x09 and 0x0A set and clear tx_en. Opcodes 0x04 and 0x03 set and clear rx_en.
- R8: Opcodes 0x0B (transmit reset), 0x05 (receive reset) and 0x00 (global reset) hold busy high for RST_CYCLES cycles, starting at the edge that accepts the write. During that time tx_rst or rx_rst is high. A transmit reset clears tx_en and a receive reset clears rx_en.
- R9: Every other command completes at its accepting edge and leaves busy low.
- R10: A write while busy is high changes no state. It sets proto_err, which stays high until rst_n.
- R11: Opcodes outside the set listed above change no output and no state.
- R12: Global reset sets the selector to 0, clears both masks, clears all latched flags and clears tx_en and rx_en. While busy it drives glob_rst, tx_rst and rx_rst high. It leaves proto_err as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Write strobe for the command port |
| cmd_data | input | 16 | Command word: opcode in 15:11, argument in 10:0 |
| stat_rd | output | 16 | Status word: bank 15:13, busy 12, flags 10:0 |
| win_sel | output | 3 | Selected register bank |
| ev_in | input | 11 | One-cycle event pulses from the datapath, one per flag |
| tx_en | output | 1 | Transmit enabled |
| rx_en | output | 1 | Receive enabled |
| tx_rst | output | 1 | Transmit reset in progress |
| rx_rst | output | 1 | Receive reset in progress |
| glob_rst | output | 1 | Global reset in progress |
| irq | output | 1 | Interrupt, equal to the interrupt latch |
| proto_err | output | 1 | Sticky flag: a write arrived while busy |

## Verification
The assertions assume cmd_wr and ev_in are known, synchronous levels. They also assume that reset-type commands are the only source of busy, so a write while busy can only follow a reset command. The stimulus changes every input on the falling edge. It holds each write for exactly one cycle. It raises event pulses for one cycle, either on their own or in the same cycle as a clear, so that the event-over-clear ordering is tested. It writes during a busy window on purpose, exactly once, and only after the earlier checks that assume proto_err is low.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
    localparam int OPC_W  = 5;
    localparam int ARG_W  = 11;
    localparam int WORD_W = OPC_W + ARG_W;
    localparam int FLG_W  = 11;

    localparam logic [OPC_W-1:0] OP_GRST  = 5'h00;
    localparam logic [OPC_W-1:0] OP_WIN   = 5'h01;
    localparam logic [OPC_W-1:0] OP_RXDIS = 5'h03;
    localparam logic [OPC_W-1:0] OP_RXEN  = 5'h04;
    localparam logic [OPC_W-1:0] OP_RXRST = 5'h05;
    localparam logic [OPC_W-1:0] OP_TXEN  = 5'h09;
    localparam logic [OPC_W-1:0] OP_TXDIS = 5'h0A;
    localparam logic [OPC_W-1:0] OP_TXRST = 5'h0B;
    localparam logic [OPC_W-1:0] OP_ACK   = 5'h0D;
    localparam logic [OPC_W-1:0] OP_IE    = 5'h0E;
    localparam logic [OPC_W-1:0] OP_IND   = 5'h0F;

    // flag bits that exist (bit 3 is reserved)
    localparam logic [FLG_W-1:0] FLG_VALID = 11'h7F7;
    // flag bits that an event pulse may set (not the latch, not bit 3)
    localparam logic [FLG_W-1:0] EV_MASK   = 11'h7F6;

    typedef struct packed {
        logic grst;
        logic win;
        logic rxdis;
        logic rxen;
        logic rxrst;
        logic txen;
        logic txdis;
        logic txrst;
        logic ack;
        logic ie;
        logic ind;
    } cmd_dec_t;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_TX   = 2'd1,
        RK_RX   = 2'd2,
        RK_ALL  = 2'd3
    } rkind_e;
endpackage

// File: rtl/hcp_cmd_decode.sv
module hcp_cmd_decode
    import hcp_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              accept_i,
    output cmd_dec_t          dec_o,
    output logic [ARG_W-1:0]  arg_o,
    output logic              is_reset_o
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc        = word_i[WORD_W-1:ARG_W];
        arg_o      = word_i[ARG_W-1:0];
        dec_o      = '0;
        is_reset_o = (opc == OP_GRST) || (opc == OP_RXRST) || (opc == OP_TXRST);
        if (accept_i) begin
            dec_o.grst  = (opc == OP_GRST);
            dec_o.win   = (opc == OP_WIN);
            dec_o.rxdis = (opc == OP_RXDIS);
            dec_o.rxen  = (opc == OP_RXEN);
            dec_o.rxrst = (opc == OP_RXRST);
            dec_o.txen  = (opc == OP_TXEN);
            dec_o.txdis = (opc == OP_TXDIS);
            dec_o.txrst = (opc == OP_TXRST);
            dec_o.ack   = (opc == OP_ACK);
            dec_o.ie    = (opc == OP_IE);
            dec_o.ind   = (opc == OP_IND);
        end
    end
endmodule

// File: rtl/hcp_busy_timer.sv
module hcp_busy_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i)
            st_d.cnt = CNT_W'(CYCLES);
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.cnt != '0);

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);                                                 // R8
    AST_BUSY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));      // R8
endmodule

// File: rtl/hcp_status_bank.sv
module hcp_status_bank
    import hcp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [FLG_W-1:0] ev_i,
    input  logic [FLG_W-1:0] ind_i,
    input  logic [FLG_W-1:0] ie_i,
    input  logic             ack_i,
    input  logic [FLG_W-1:0] ack_mask_i,
    output logic [FLG_W-1:0] flags_o
);
    typedef struct packed {
        logic [FLG_W-1:0] flags;
    } bank_st_t;

    bank_st_t         st_d, st_q;
    logic [FLG_W-1:0] fresh;
    logic             raise;

    always_comb begin
        st_d  = st_q;
        fresh = ev_i & ind_i & EV_MASK;
        raise = |(fresh & ie_i & EV_MASK);
        if (ack_i)
            st_d.flags = st_q.flags & ~ack_mask_i;
        st_d.flags = (st_d.flags | fresh) & FLG_VALID;
        if (raise)
            st_d.flags[0] = 1'b1;
        if (clear_i)
            st_d.flags = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    AST_NO_UNINDICATED_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.flags[FLG_W-1:1] & ~$past(st_q.flags[FLG_W-1:1])
                   & ~$past(ind_i[FLG_W-1:1])) == '0));                      // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && ev_i == '0 && !clear_i) |=> ((st_q.flags & $past(ack_mask_i)) == '0)); // R5
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.flags[3]);                                                     // R3
endmodule

// File: rtl/hcp_top.sv
module hcp_top
    import hcp_pkg::*;
#(
    parameter int RST_CYCLES = 16,
    parameter int NUM_WIN    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [15:0] cmd_data,
    output logic [15:0] stat_rd,
    output logic [2:0]  win_sel,
    input  logic [10:0] ev_in,
    output logic        tx_en,
    output logic        rx_en,
    output logic        tx_rst,
    output logic        rx_rst,
    output logic        glob_rst,
    output logic        irq,
    output logic        proto_err
);
    localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [FLG_W-1:0] ie;
        logic [FLG_W-1:0] ind;
        logic             txen;
        logic             rxen;
        logic             perr;
        rkind_e           rk;
    } top_st_t;

    top_st_t          st_d, st_q;
    cmd_dec_t         dec;
    logic [ARG_W-1:0] arg;
    logic             is_reset;
    logic             busy;
    logic             accept;
    logic             start_rst;
    logic [FLG_W-1:0] flags;
    logic [2:0]       win_ext;

    assign accept    = cmd_wr && !busy;
    assign start_rst = accept && is_reset;

    hcp_cmd_decode u_dec (
        .word_i     (cmd_data),
        .accept_i   (accept),
        .dec_o      (dec),
        .arg_o      (arg),
        .is_reset_o (is_reset)
    );

    hcp_busy_timer #(.CYCLES(RST_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_rst),
        .busy_o  (busy)
    );

    hcp_status_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (dec.grst),
        .ev_i       (ev_in),
        .ind_i      (st_q.ind),
        .ie_i       (st_q.ie),
        .ack_i      (dec.ack),
        .ack_mask_i (arg),
        .flags_o    (flags)
    );

    always_comb begin
        st_d = st_q;
        if (cmd_wr && busy)
            st_d.perr = 1'b1;
        if (dec.win)   st_d.win  = arg[WIN_W-1:0];
        if (dec.ie)    st_d.ie   = arg & FLG_VALID;
        if (dec.ind)   st_d.ind  = arg & FLG_VALID;
        if (dec.txen)  st_d.txen = 1'b1;
        if (dec.txdis) st_d.txen = 1'b0;
        if (dec.rxen)  st_d.rxen = 1'b1;
        if (dec.rxdis) st_d.rxen = 1'b0;
        if (dec.txrst) begin
            st_d.txen = 1'b0;
            st_d.rk   = RK_TX;
        end
        if (dec.rxrst) begin
            st_d.rxen = 1'b0;
            st_d.rk   = RK_RX;
        end
        if (dec.grst) begin
            st_d.win  = '0;
            st_d.ie   = '0;
            st_d.ind  = '0;
            st_d.txen = 1'b0;
            st_d.rxen = 1'b0;
            st_d.rk   = RK_ALL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        win_ext = '0;
        win_ext[WIN_W-1:0] = st_q.win;
    end

    assign stat_rd   = {win_ext, busy, 1'b0, flags};
    assign win_sel   = win_ext;
    assign tx_en     = st_q.txen;
    assign rx_en     = st_q.rxen;
    assign tx_rst    = busy && (st_q.rk == RK_TX || st_q.rk == RK_ALL);
    assign rx_rst    = busy && (st_q.rk == RK_RX || st_q.rk == RK_ALL);
    assign glob_rst  = busy && (st_q.rk == RK_ALL);
    assign irq       = flags[0];
    assign proto_err = st_q.perr;

    AST_WIN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && cmd_data[15:11] == OP_WIN)
        |=> (win_sel[WIN_W-1:0] == $past(cmd_data[WIN_W-1:0])));           // R2
    AST_PLAIN_CMD_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && cmd_data[15:11] != OP_GRST
         && cmd_data[15:11] != OP_RXRST && cmd_data[15:11] != OP_TXRST) |=> !stat_rd[12]); // R9
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> ($stable(win_sel) && $stable(tx_en) && $stable(rx_en) && proto_err)); // R10
    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);                                            // R10
    AST_GRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && cmd_data[15:11] == OP_GRST)
        |=> (win_sel == 3'd0 && !tx_en && !rx_en && stat_rd[10:0] == '0 && glob_rst)); // R12
endmodule

// File: tb/hcp_top_tb.sv
module hcp_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RSTC       = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_data = '0;
    logic [10:0] ev_in = '0;
    logic [15:0] stat_rd;
    logic [2:0]  win_sel;
    logic        tx_en, rx_en, tx_rst, rx_rst, glob_rst, irq, proto_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [25:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    hcp_top #(.RST_CYCLES(RSTC), .NUM_WIN(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .stat_rd(stat_rd), .win_sel(win_sel), .ev_in(ev_in),
        .tx_en(tx_en), .rx_en(rx_en), .tx_rst(tx_rst), .rx_rst(rx_rst),
        .glob_rst(glob_rst), .irq(irq), .proto_err(proto_err)
    );

    function automatic logic [25:0] ob(logic [15:0] s, logic te, logic re, logic tr,
                                       logic rr, logic gr, logic iq, logic pe);
        return {s, te, re, tr, rr, gr, iq, pe, s[15:13]};
    endfunction

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [25:0] got;
                it  = sb_q.pop_front();
                got = {stat_rd, tx_en, rx_en, tx_rst, rx_rst, glob_rst, irq, proto_err, win_sel};
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s got %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic chk(logic [25:0] e, string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    task automatic wr(logic [4:0] op, logic [10:0] a);
        cmd_wr   = 1'b1;
        cmd_data = {op, a};
        @(negedge clk);
        cmd_wr   = 1'b0;
        cmd_data = '0;
    endtask

    task automatic pulse(logic [10:0] e);
        ev_in = e;
        @(negedge clk);
        ev_in = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ob(16'h0000,0,0,0,0,0,0,0), "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(ob(16'h0000,0,0,0,0,0,0,0), "R1 after reset");

        wr(5'h01, 11'h005);
        chk(ob(16'hA000,0,0,0,0,0,0,0), "R2 window 5, R9 no busy");
        wr(5'h01, 11'h7FB);
        chk(ob(16'h6000,0,0,0,0,0,0,0), "R2 upper argument bits ignored");

        wr(5'h0F, 11'h014);
        wr(5'h0E, 11'h010);
        pulse(11'h11D);
        chk(ob(16'h6015,0,0,0,0,0,1,0), "R4 R6 indicated events latch, latch bit set");

        wr(5'h0D, 11'h661);
        chk(ob(16'h6014,0,0,0,0,0,0,0), "R5 ack 0x661 clears latch");
        wr(5'h0D, 11'h014);
        chk(ob(16'h6000,0,0,0,0,0,0,0), "R5 ack clears bits 2 and 4");

        // event and clear in the same cycle: event wins
        cmd_wr   = 1'b1;
        cmd_data = {5'h0D, 11'h004};
        ev_in    = 11'h004;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_data = '0; ev_in = '0;
        chk(ob(16'h6004,0,0,0,0,0,0,0), "R5 event beats same-cycle clear");
        wr(5'h0D, 11'h004);

        wr(5'h0F, 11'h7FF);
        wr(5'h0E, 11'h000);
        pulse(11'h7FF);
        chk(ob(16'h67F6,0,0,0,0,0,0,0), "R4 R3 bits 0 and 3 never latch from events");
        wr(5'h0D, 11'h7FF);
        chk(ob(16'h6000,0,0,0,0,0,0,0), "R5 full clear");

        wr(5'h09, 11'h000);
        chk(ob(16'h6000,1,0,0,0,0,0,0), "R7 tx enable");
        wr(5'h04, 11'h000);
        chk(ob(16'h6000,1,1,0,0,0,0,0), "R7 rx enable");
        wr(5'h0A, 11'h000);
        chk(ob(16'h6000,0,1,0,0,0,0,0), "R7 tx disable");
        wr(5'h03, 11'h000);
        chk(ob(16'h6000,0,0,0,0,0,0,0), "R7 rx disable");
        wr(5'h04, 11'h000);
        wr(5'h09, 11'h000);

        wr(5'h0B, 11'h000);
        chk(ob(16'h7000,0,1,1,0,0,0,0), "R8 tx reset busy start");
        repeat (RSTC-1) @(negedge clk);
        chk(ob(16'h7000,0,1,1,0,0,0,0), "R8 tx reset busy last cycle");
        @(negedge clk);
        chk(ob(16'h6000,0,1,0,0,0,0,0), "R8 tx reset done");

        wr(5'h01, 11'h002);
        chk(ob(16'h4000,0,1,0,0,0,0,0), "R9 window command not busy");

        wr(5'h05, 11'h000);
        wr(5'h01, 11'h006);
        chk(ob(16'h5000,0,0,0,1,0,0,1), "R10 write while busy ignored");
        repeat (RSTC+4) @(negedge clk);
        chk(ob(16'h4000,0,0,0,0,0,0,1), "R10 protocol error sticky");

        wr(5'h1F, 11'h7FF);
        wr(5'h02, 11'h7FF);
        wr(5'h0C, 11'h7FF);
        chk(ob(16'h4000,0,0,0,0,0,0,1), "R11 unlisted opcodes no effect");

        wr(5'h09, 11'h000);
        wr(5'h04, 11'h000);
        wr(5'h0F, 11'h010);
        wr(5'h0E, 11'h010);
        pulse(11'h010);
        chk(ob(16'h4011,1,1,0,0,0,1,1), "R6 irq from enabled event");
        wr(5'h00, 11'h000);
        chk(ob(16'h1000,0,0,1,1,1,0,1), "R12 global reset clears state");
        repeat (RSTC) @(negedge clk);
        pulse(11'h7FF);
        chk(ob(16'h0000,0,0,0,0,0,0,1), "R12 masks cleared, nothing latches");

        #1;
        -> sample_ev;
        #1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule